// File: doc/BRIEF.md
# Frame Histogram Engine with Change-Detection Interrupt

This block watches a pixel stream and, over each active frame, counts how many pixels fall into each of 32 brightness bins. At every vertical-blank strobe the finished counts are copied into a readout bank, and the bank that was there before becomes the previous-frame bank. A sequential scanner then adds up the absolute per-bin differences between the two banks. If that sum is larger than four times a programmed threshold, a sticky event status is set and an interrupt can be raised. A delay setting keeps events from being reported too close together.

Software drives the engine through three small registers: a control register, a guardband register and an indexed bin-data port. A new enable, binning mode or port function does not act on the write. It is held in a shadow copy and takes effect at the next vertical blank. Disabling is the one exception, and it acts on the write itself. Bin counts are read one at a time through the data port, and an internal index advances after each read.

Top module: `frame_hist_engine`

## Requirements
- R1: After reset, irq is 0, the control register (address 0) reads 0, and the guardband register (address 1) reads 0x0400_0000, which is a delay of 4 with every other field at 0.
- R2: In value mode (control bit 2 = 0), each valid pixel counts into bin max(R,G,B)>>3. Counts are 24 bits wide. At the vblank that follows, the frame's counts become readable on the data port (address 2, bits 23:0).
- R3: In luma mode (control bit 2 = 1), each valid pixel counts into bin ((R+2G+B)>>2)>>3.
- R4: The enable (control bit 0), port function (bit 1: 0 = statistics, 1 = table access) and mode written to the control register become active only at the next vblank. The active enable reads back on control bit 16 and the active function on bit 17.
- R5: A write to the control register loads the bin index from bits 12:8. In statistics mode, each data-port read returns the bin at the index and then moves the index on by one, wrapping from 31 to 0. Control bits 12:8 read back the live index.
- R6: While table-access mode is active, the data port reads 0 and the index does not move.
- R7: Once a frame has been latched, and only when the previous bank also holds a frame counted while enabled, a summed absolute bin difference greater than threshold×4 sets status (guardband bit 31). Bits 23:0 of the guardband register hold the threshold. The earliest such event follows the third vblank after the enable write.
- R8: A summed difference equal to or below threshold×4 does not set status.
- R9: After an event is reported, the next N comparisons cannot report one, where N is the delay field (guardband bits 27:24).
- R10: A guardband write with bit 31 set only clears status and leaves threshold, delay and interrupt enable unchanged. If that clear lands in the same cycle as a new event, status ends set.
- R11: irq is status AND interrupt enable (guardband bit 28). With bit 28 at 0, status still records the event but irq stays low.
- R12: A control write with bit 0 at 0 acts at once: the active enable drops, status clears, irq goes low, and vblanks seen while disabled latch nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pixValid | input | 1 | Pixel qualifier |
| pixR | input | 8 | Red component |
| pixG | input | 8 | Green component |
| pixB | input | 8 | Blue component |
| frameStart | input | 1 | One-cycle strobe at the start of a frame; clears the running counts |
| vblank | input | 1 | One-cycle vertical-blank strobe |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address: 0 control, 1 guardband, 2 data port |
| regWrData | input | 32 | Register write data |
| regRdEn | input | 1 | Register read strobe; advances the bin index on data-port reads |
| regRdData | output | 32 | Register read data for regAddr |
| irq | output | 1 | Change-detection interrupt |

## Verification
The scanner's completion and a status-clear write from software can fall in the same cycle. The bench provokes this by counting exactly 33 clock edges after the vblank edge that latched a qualifying frame, then placing the clear write so that it is sampled at that edge. The status bit must then still read 1, because the new event has priority over the clear. The same counting is used to place the ordinary clear writes well away from a scan, so that the two outcomes can be told apart.

// File: rtl/frame_hist_pkg.sv
`timescale 1ns/1ps
package frame_hist_pkg;
  parameter int BIN_LOG2 = 5;
  parameter int CNT_W    = 24;
  parameter int THR_W    = 24;
  parameter int DLY_W    = 4;
  localparam int NUM_BINS = 1 << BIN_LOG2;
  localparam int SUM_W    = CNT_W + BIN_LOG2;

  localparam logic [1:0] ADDR_CTRL  = 2'd0;
  localparam logic [1:0] ADDR_GUARD = 2'd1;
  localparam logic [1:0] ADDR_DATA  = 2'd2;

  // strobes from control to datapath
  typedef struct packed {
    logic                countEn;
    logic                clearCount;
    logic                latchBank;
    logic                lumaMode;
    logic [BIN_LOG2-1:0] rdIdx;
  } dp_ctrl_t;
endpackage

// File: rtl/frame_hist_datapath.sv
`timescale 1ns/1ps
module frame_hist_datapath
  import frame_hist_pkg::*;
#(
  parameter int CH_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pixValid,
  input  logic [CH_W-1:0]   pixR,
  input  logic [CH_W-1:0]   pixG,
  input  logic [CH_W-1:0]   pixB,
  input  logic              vblank,
  input  dp_ctrl_t          ctl,
  output logic [CNT_W-1:0]  rdBin,
  output logic              scanDone,
  output logic [SUM_W-1:0]  diffSum
);
  logic [CH_W-1:0]     maxRG, valueComp, lumaComp, binSrc;
  logic [CH_W+1:0]     lumaSum;
  logic [BIN_LOG2-1:0] pixBin;
  logic                pixHit;
  logic [NUM_BINS-1:0] hitVec;

  logic [CNT_W-1:0] cnt      [NUM_BINS];
  logic [CNT_W-1:0] bankNow  [NUM_BINS];
  logic [CNT_W-1:0] bankPrev [NUM_BINS];

  always_comb begin
    maxRG     = (pixR > pixG) ? pixR : pixG;
    valueComp = (maxRG > pixB) ? maxRG : pixB;
    lumaSum   = {2'b00, pixR} + {1'b0, pixG, 1'b0} + {2'b00, pixB};
    lumaComp  = lumaSum[CH_W+1:2];
    binSrc    = ctl.lumaMode ? lumaComp : valueComp;
    pixBin    = binSrc[CH_W-1 -: BIN_LOG2];
    pixHit    = pixValid && ctl.countEn && !vblank;
  end

  // one-hot hit per bin
  for (genvar b = 0; b < NUM_BINS; b++) begin : g_hit
    assign hitVec[b] = pixHit && (pixBin == BIN_LOG2'(b));
  end

  // running counters, saturating
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < NUM_BINS; b++) cnt[b] <= '0;
    end else begin
      for (int b = 0; b < NUM_BINS; b++) begin
        if (ctl.clearCount)
          cnt[b] <= {{(CNT_W-1){1'b0}}, hitVec[b]};
        else if (hitVec[b] && (cnt[b] != {CNT_W{1'b1}}))
          cnt[b] <= cnt[b] + 1'b1;
      end
    end
  end

  // readout and previous banks
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < NUM_BINS; b++) begin
        bankNow[b]  <= '0;
        bankPrev[b] <= '0;
      end
    end else if (ctl.latchBank) begin
      for (int b = 0; b < NUM_BINS; b++) begin
        bankNow[b]  <= cnt[b];
        bankPrev[b] <= bankNow[b];
      end
    end
  end

  // sequential difference scanner, one bin per cycle
  logic                scanning;
  logic [BIN_LOG2-1:0] scanIdx;
  logic [SUM_W-1:0]    acc;
  logic [CNT_W-1:0]    curV, prvV, binDelta;

  always_comb begin
    curV     = bankNow[scanIdx];
    prvV     = bankPrev[scanIdx];
    binDelta = (curV >= prvV) ? (curV - prvV) : (prvV - curV);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scanning <= 1'b0;
      scanIdx  <= '0;
      acc      <= '0;
      scanDone <= 1'b0;
    end else begin
      scanDone <= 1'b0;
      if (ctl.latchBank) begin
        scanning <= 1'b1;
        scanIdx  <= '0;
        acc      <= '0;
      end else if (scanning) begin
        acc     <= acc + SUM_W'(binDelta);
        scanIdx <= scanIdx + 1'b1;
        if (scanIdx == BIN_LOG2'(NUM_BINS - 1)) begin
          scanning <= 1'b0;
          scanDone <= 1'b1;
        end
      end
    end
  end

  assign diffSum = acc;
  assign rdBin   = bankNow[ctl.rdIdx];
endmodule

// File: rtl/frame_hist_ctrl.sv
`timescale 1ns/1ps
module frame_hist_ctrl
  import frame_hist_pkg::*;
#(
  parameter int DLY_DEF = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frameStart,
  input  logic                vblank,
  input  logic                regWrEn,
  input  logic [1:0]          regAddr,
  input  logic [31:0]         regWrData,
  input  logic                regRdEn,
  output logic [31:0]         regRdData,
  input  logic [CNT_W-1:0]    rdBin,
  input  logic                scanDone,
  input  logic [SUM_W-1:0]    diffSum,
  output dp_ctrl_t            dpCtl,
  output logic                irq,
  output logic                obsActiveEn,
  output logic                obsActiveFn,
  output logic                obsStatus,
  output logic                obsIntEn,
  output logic [BIN_LOG2-1:0] obsIdx,
  output logic [THR_W-1:0]    obsThr
);
  logic shEn, shFn, shMode;
  logic actEn, actFn, actMode;
  logic [BIN_LOG2-1:0] idxQ;
  logic [THR_W-1:0]    thrQ;
  logic [DLY_W-1:0]    delayQ, gapQ;
  logic                intEnQ, statusQ;
  logic [1:0]          validCnt;

  logic wrCtrl, wrGuard, clrReq, progGuard, rdData, disableNow;
  logic cmpReady, exceed, fire;

  always_comb begin
    wrCtrl     = regWrEn && (regAddr == ADDR_CTRL);
    wrGuard    = regWrEn && (regAddr == ADDR_GUARD);
    clrReq     = wrGuard && regWrData[31];
    progGuard  = wrGuard && !regWrData[31];
    rdData     = regRdEn && (regAddr == ADDR_DATA) && !actFn;
    disableNow = wrCtrl && !regWrData[0];
    exceed     = diffSum > SUM_W'({thrQ, 2'b00});
    cmpReady   = scanDone && actEn && (validCnt == 2'd2);
    fire       = cmpReady && exceed && (gapQ >= delayQ);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shEn <= 1'b0; shFn <= 1'b0; shMode <= 1'b0;
      actEn <= 1'b0; actFn <= 1'b0; actMode <= 1'b0;
      idxQ <= '0;
      thrQ <= '0;
      delayQ <= DLY_W'(DLY_DEF);
      intEnQ <= 1'b0;
      statusQ <= 1'b0;
      validCnt <= 2'd0;
      gapQ <= '1;
    end else begin
      if (wrCtrl) begin
        shEn   <= regWrData[0];
        shFn   <= regWrData[1];
        shMode <= regWrData[2];
      end
      // enable waits for vblank, disable acts at once
      if (disableNow)  actEn <= 1'b0;
      else if (vblank) actEn <= shEn;
      if (vblank) begin
        actFn   <= shFn;
        actMode <= shMode;
      end
      if (wrCtrl)      idxQ <= regWrData[8 +: BIN_LOG2];
      else if (rdData) idxQ <= idxQ + 1'b1;

      if (disableNow || !actEn) validCnt <= 2'd0;
      else if (dpCtl.latchBank && validCnt != 2'd2) validCnt <= validCnt + 1'b1;

      if (disableNow || !actEn) gapQ <= '1;
      else if (cmpReady) begin
        if (fire)            gapQ <= '0;
        else if (gapQ != '1) gapQ <= gapQ + 1'b1;
      end

      if (progGuard) begin
        thrQ   <= regWrData[THR_W-1:0];
        delayQ <= regWrData[24 +: DLY_W];
        intEnQ <= regWrData[28];
      end

      // a new event outranks a clear in the same cycle
      if (disableNow || !actEn) statusQ <= 1'b0;
      else if (fire)            statusQ <= 1'b1;
      else if (clrReq)          statusQ <= 1'b0;
    end
  end

  always_comb begin
    dpCtl.countEn    = actEn;
    dpCtl.clearCount = frameStart || vblank || !actEn;
    dpCtl.latchBank  = vblank && actEn;
    dpCtl.lumaMode   = actMode;
    dpCtl.rdIdx      = idxQ;
  end

  always_comb begin
    regRdData = '0;
    case (regAddr)
      ADDR_CTRL: begin
        regRdData[0]              = shEn;
        regRdData[1]              = shFn;
        regRdData[2]              = shMode;
        regRdData[8 +: BIN_LOG2]  = idxQ;
        regRdData[16]             = actEn;
        regRdData[17]             = actFn;
      end
      ADDR_GUARD: begin
        regRdData[THR_W-1:0]      = thrQ;
        regRdData[24 +: DLY_W]    = delayQ;
        regRdData[28]             = intEnQ;
        regRdData[31]             = statusQ;
      end
      ADDR_DATA: begin
        if (!actFn) regRdData[CNT_W-1:0] = rdBin;
      end
      default: regRdData = '0;
    endcase
  end

  assign irq         = statusQ && intEnQ;
  assign obsActiveEn = actEn;
  assign obsActiveFn = actFn;
  assign obsStatus   = statusQ;
  assign obsIntEn    = intEnQ;
  assign obsIdx      = idxQ;
  assign obsThr      = thrQ;
endmodule

// File: rtl/frame_hist_engine.sv
`timescale 1ns/1ps
module frame_hist_engine
  import frame_hist_pkg::*;
#(
  parameter int CH_W    = 8,
  parameter int DLY_DEF = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pixValid,
  input  logic [CH_W-1:0] pixR,
  input  logic [CH_W-1:0] pixG,
  input  logic [CH_W-1:0] pixB,
  input  logic            frameStart,
  input  logic            vblank,
  input  logic            regWrEn,
  input  logic [1:0]      regAddr,
  input  logic [31:0]     regWrData,
  input  logic            regRdEn,
  output logic [31:0]     regRdData,
  output logic            irq
);
  dp_ctrl_t            dpCtl;
  logic [CNT_W-1:0]    rdBin;
  logic                scanDone;
  logic [SUM_W-1:0]    diffSum;
  logic                obsActiveEn, obsActiveFn, obsStatus, obsIntEn;
  logic [BIN_LOG2-1:0] obsIdx;
  logic [THR_W-1:0]    obsThr;

  frame_hist_ctrl #(.DLY_DEF(DLY_DEF)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .frameStart(frameStart), .vblank(vblank),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdEn(regRdEn), .regRdData(regRdData), .rdBin(rdBin),
    .scanDone(scanDone), .diffSum(diffSum), .dpCtl(dpCtl), .irq(irq),
    .obsActiveEn(obsActiveEn), .obsActiveFn(obsActiveFn), .obsStatus(obsStatus),
    .obsIntEn(obsIntEn), .obsIdx(obsIdx), .obsThr(obsThr)
  );

  frame_hist_datapath #(.CH_W(CH_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .pixValid(pixValid), .pixR(pixR), .pixG(pixG),
    .pixB(pixB), .vblank(vblank), .ctl(dpCtl), .rdBin(rdBin),
    .scanDone(scanDone), .diffSum(diffSum)
  );
endmodule

// File: rtl/frame_hist_checker.sv
`timescale 1ns/1ps
module frame_hist_checker
  import frame_hist_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                regWrEn,
  input logic [1:0]          regAddr,
  input logic [31:0]         regWrData,
  input logic                regRdEn,
  input logic                vblank,
  input logic                irq,
  input logic                scanDone,
  input logic                activeEn,
  input logic                activeFn,
  input logic                status,
  input logic                intEn,
  input logic [BIN_LOG2-1:0] rdIdx,
  input logic [THR_W-1:0]    thr
);
  AST_EN_AT_VBLANK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(activeEn) |-> $past(vblank)); // R4

  AST_DISABLE_NOW: assert property (@(posedge clk) disable iff (!rst_n)
    (regWrEn && regAddr == 2'd0 && !regWrData[0]) |=> (!activeEn && !status && !irq)); // R12

  AST_STATUS_FROM_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status) |-> $past(scanDone)); // R7

  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (regRdEn && !regWrEn && regAddr == 2'd2 && !activeFn) |=> (rdIdx == BIN_LOG2'($past(rdIdx) + 1'b1))); // R5

  AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (regRdEn && !regWrEn && regAddr == 2'd2 && activeFn) |=> $stable(rdIdx)); // R6

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    !intEn |-> !irq); // R11

  AST_CLEAR_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (regWrEn && regAddr == 2'd1 && regWrData[31]) |=> $stable(thr)); // R10
endmodule

bind frame_hist_engine frame_hist_checker u_chk (
  .clk(clk), .rst_n(rst_n), .regWrEn(regWrEn), .regAddr(regAddr),
  .regWrData(regWrData), .regRdEn(regRdEn), .vblank(vblank), .irq(irq),
  .scanDone(scanDone), .activeEn(obsActiveEn), .activeFn(obsActiveFn),
  .status(obsStatus), .intEn(obsIntEn), .rdIdx(obsIdx), .thr(obsThr)
);

// File: tb/frame_hist_engine_bench.sv
`timescale 1ns/1ps
module frame_hist_engine_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pixValid = 1'b0;
  logic [7:0]  pixR = '0, pixG = '0, pixB = '0;
  logic        frameStart = 1'b0, vblank = 1'b0;
  logic        regWrEn = 1'b0, regRdEn = 1'b0;
  logic [1:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        irq;
  logic        probeIrq = 1'b0;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  int modelCnt[32];
  int modelBank[32];

  typedef struct {
    bit          isIrq;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sbq[$];

  always #5 clk = ~clk;

  frame_hist_engine u_frame_hist_engine (
    .clk(clk), .rst_n(rst_n), .pixValid(pixValid), .pixR(pixR), .pixG(pixG),
    .pixB(pixB), .frameStart(frameStart), .vblank(vblank), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdEn(regRdEn),
    .regRdData(regRdData), .irq(irq)
  );

  // monitor: samples mid low phase, pops and compares
  always begin
    @(negedge clk);
    #2;
    if (regRdEn || probeIrq) begin
      if (sbq.size() == 0) begin
        mismatched++;
        $display("FAIL [scoreboard] empty queue actual=item expected=none");
      end else begin
        item_t it;
        logic [31:0] act;
        it = sbq.pop_front();
        act = it.isIrq ? {31'b0, irq} : regRdData;
        compared++;
        if (act !== it.exp) begin
          mismatched++;
          $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
        end
      end
    end
  end

  function automatic int binOf(int r, int g, int b, bit luma);
    int m;
    if (luma) return ((r + 2*g + b) / 4) / 8;
    m = (r > g) ? r : g;
    m = (m > b) ? m : b;
    return m / 8;
  endfunction

  task automatic regWrite(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk); regWrEn = 1'b0;
  endtask

  task automatic expectReg(input logic [1:0] a, input logic [31:0] e, input string tag);
    item_t it;
    @(negedge clk);
    regAddr = a; regRdEn = 1'b1;
    it.isIrq = 1'b0; it.exp = e; it.tag = tag;
    sbq.push_back(it);
    @(negedge clk); regRdEn = 1'b0;
  endtask

  task automatic expectIrq(input logic e, input string tag);
    item_t it;
    @(negedge clk);
    probeIrq = 1'b1;
    it.isIrq = 1'b1; it.exp = {31'b0, e}; it.tag = tag;
    sbq.push_back(it);
    @(negedge clk); probeIrq = 1'b0;
  endtask

  // bin i gets i+1 pixels; 'moved' pixels go from bin 10 to bin 20
  task automatic sendFrame(input int moved, input bit luma, input bit counted);
    @(negedge clk); frameStart = 1'b1;
    @(negedge clk); frameStart = 1'b0;
    for (int i = 0; i < 32; i++) modelCnt[i] = 0;
    for (int i = 0; i < 32; i++) begin
      int n;
      n = i + 1;
      if (i == 10) n -= moved;
      if (i == 20) n += moved;
      for (int k = 0; k < n; k++) begin
        int v, r, g, b;
        if (luma) begin
          v = i*8 + (k % 4)*2;
          if (k % 2 == 1) begin r = v + 1; g = v; b = v - 1; end
          else begin r = v; g = v; b = v; end
        end else begin
          v = i*8 + (k % 8);
          case (k % 3)
            0: begin r = v;   g = v/2; b = v/3; end
            1: begin r = v/3; g = v;   b = v/2; end
            default: begin r = 0; g = v/4; b = v; end
          endcase
        end
        @(negedge clk);
        pixValid = 1'b1; pixR = 8'(r); pixG = 8'(g); pixB = 8'(b);
        if (counted) modelCnt[binOf(r, g, b, luma)]++;
      end
    end
    @(negedge clk); pixValid = 1'b0;
  endtask

  task automatic vblankPulse(input bit latch);
    @(negedge clk); vblank = 1'b1;
    @(negedge clk); vblank = 1'b0;
    if (latch) for (int i = 0; i < 32; i++) modelBank[i] = modelCnt[i];
    for (int i = 0; i < 32; i++) modelCnt[i] = 0;
  endtask

  task automatic waitScan();
    repeat (40) @(negedge clk);
  endtask

  task automatic readBins(input string tag);
    for (int i = 0; i < 32; i++) expectReg(2'd2, modelBank[i], tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL [watchdog] actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) begin modelCnt[i] = 0; modelBank[i] = 0; end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    expectReg(2'd0, 32'h0000_0000, "R1 control after reset");
    expectReg(2'd1, 32'h0400_0000, "R1 guardband after reset");
    expectIrq(1'b0, "R1 irq after reset");

    // threshold 2 (scaled 8), delay 1, interrupt enable
    regWrite(2'd1, 32'h1100_0002);
    expectReg(2'd1, 32'h1100_0002, "R11 guardband fields");
    regWrite(2'd0, 32'h0000_0001);
    expectReg(2'd0, 32'h0000_0001, "R4 enable pending before vblank");
    vblankPulse(1'b0);
    expectReg(2'd0, 32'h0001_0001, "R4 enable active after vblank");

    // frame A: first latched frame, no event
    sendFrame(0, 1'b0, 1'b1);
    vblankPulse(1'b1);
    waitScan();
    expectIrq(1'b0, "R7 no event on first frame");
    expectReg(2'd1, 32'h1100_0002, "R7 status clear after first frame");
    readBins("R2 value-mode bin");
    expectReg(2'd2, modelBank[0], "R5 index wraps to bin 0");
    expectReg(2'd0, 32'h0001_0101, "R5 live index after 33 reads");

    // frame B identical
    sendFrame(0, 1'b0, 1'b1);
    vblankPulse(1'b1);
    waitScan();
    expectIrq(1'b0, "R8 identical frames");

    // frame C: difference 8 == threshold*4
    sendFrame(4, 1'b0, 1'b1);
    vblankPulse(1'b1);
    waitScan();
    expectIrq(1'b0, "R8 equal to scaled threshold");
    expectReg(2'd1, 32'h1100_0002, "R8 status stays clear");

    // frame D: difference 10 > 8
    sendFrame(9, 1'b0, 1'b1);
    vblankPulse(1'b1);
    waitScan();
    expectIrq(1'b1, "R7 event raises irq");
    expectReg(2'd1, 32'h9100_0002, "R7 status set");
    regWrite(2'd0, 32'h0000_0A01);
    expectReg(2'd2, modelBank[10], "R5 index load from control write");

    // R10 clear-only write
    regWrite(2'd1, 32'h8000_0000);
    expectReg(2'd1, 32'h1100_0002, "R10 clear keeps other fields");
    expectIrq(1'b0, "R10 irq low after clear");

    // frame E: difference 10 but within delay window
    sendFrame(4, 1'b0, 1'b1);
    vblankPulse(1'b1);
    waitScan();
    expectIrq(1'b0, "R9 event held off by delay");
    expectReg(2'd1, 32'h1100_0002, "R9 status stays clear");

    // frame F: event allowed; clear write sampled at the edge status is set
    sendFrame(9, 1'b0, 1'b1);
    vblankPulse(1'b1);
    repeat (31) @(negedge clk);
    regWrite(2'd1, 32'h8000_0000);
    repeat (5) @(negedge clk);
    expectReg(2'd1, 32'h9100_0002, "R10 coincident event wins over clear");
    expectIrq(1'b1, "R9 event after delay elapsed");

    // R11 mask interrupt, status kept
    regWrite(2'd1, 32'h0100_0002);
    expectIrq(1'b0, "R11 irq masked");
    expectReg(2'd1, 32'h8100_0002, "R11 status still recorded");

    // R6 table-access mode
    regWrite(2'd0, 32'h0000_0303);
    expectReg(2'd2, modelBank[3], "R4 function change pending");
    vblankPulse(1'b1);
    waitScan();
    expectReg(2'd2, 32'h0000_0000, "R6 data port reads zero");
    expectReg(2'd2, 32'h0000_0000, "R6 data port reads zero again");
    expectReg(2'd0, 32'h0003_0403, "R6 index held in table mode");

    // R12 immediate disable
    regWrite(2'd0, 32'h0000_0000);
    expectReg(2'd0, 32'h0002_0000, "R12 active enable drops at once");
    expectReg(2'd1, 32'h0100_0002, "R12 status cleared by disable");
    expectIrq(1'b0, "R12 irq low after disable");
    sendFrame(0, 1'b1, 1'b0);
    vblankPulse(1'b0);
    regWrite(2'd0, 32'h0000_0300);
    expectReg(2'd2, modelBank[3], "R12 no latch while disabled");

    // R3 luma mode
    regWrite(2'd0, 32'h0000_0005);
    vblankPulse(1'b0);
    sendFrame(0, 1'b1, 1'b1);
    vblankPulse(1'b1);
    waitScan();
    regWrite(2'd0, 32'h0000_0005);
    readBins("R3 luma-mode bin");

    repeat (4) @(negedge clk);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule